// File: doc/BRIEF.md
# Instruction Trap Filter

This block holds a 64-bit trap control word that code at the hypervisor level writes. It judges each decoded system instruction presented to it, together with the level it runs at and the machine's current configuration. It decides whether that instruction must be diverted to the hypervisor level and which exception class code goes with the diversion. Every live bit of the word stands for one instruction group, and the instruction-class index carries that bit's position. Some bits cover only EL1. Some cover EL0 and EL1 together. One bit covers supervisor calls made from EL0.

Each live bit is qualified by three things. The first is whether the hypervisor is present and active in the current security state. The second is the outermost level's enable: it applies only when that level exists. The third is the host-mode pair {E2H,TGE}, which applies only to bits that reach EL0. Bits tied to an optional feature hold zero while that feature is absent. An exception of higher priority on the same instruction cancels the trap.

A small sequencer turns each decision into one registered pulse. It has three states:
- ST_IDLE evaluates the request and moves to ST_FIRE when a trap is due. Otherwise it stays in ST_IDLE.
- ST_FIRE drives the pulse for exactly one cycle. It moves to ST_HOLD if the request is still present, or back to ST_IDLE if it has gone.
- ST_HOLD ignores the request that is still being held and returns to ST_IDLE once `req_valid` falls.

Top module: `instr_trap_filter`

## Requirements
- R1: After reset the control word reads 0, `trap_pulse` is 0, `trap_class` is 0 and `trap_target` is 0.
- R2: Bits 63 to 55 of the control word always read 0, even after a write of all ones.
- R3: The optional-feature bits keep their written value only while their feature flag is 1; otherwise they read 0 and have no effect. The `feat_avail` bits are:
  - bit 0: range invalidate, which gates bits 41..34 and 27..24.
  - bit 1: outer-shareable invalidate, which gates bits 27..18.
  - bit 2: privileged translate variants, which gates bits 17..16.
  - bit 3: prediction restriction, which gates bits 50..48.
  - bit 4: deep-persistence clean, which gates bit 9.
- R4: A request whose control bit is 0 raises no trap.
- R5: A trap needs both `hyp_impl` and `hyp_on_sec` to be 1, and needs either `outer_present`=0 or `outer_trap_en`=1.
- R6: When `host_e2h`=`host_tge`=1, the bits covering EL0 and EL1 (54, 50..48, 11..7) and the EL0 supervisor-call bit 52 do not trap; the EL1-only bits still trap.
- R7: `req_level` is encoded 0=EL0, 1=EL1, 2=hypervisor level, 3=outermost level. EL1-only bits trap only at level 1, bits 54, 50..48 and 11..7 trap at levels 0 and 1, bit 52 traps only at level 0, and levels 2 and 3 never trap.
- R8: A trap reports `trap_target`=2. Bits 53 and 52 report class 0x15, bit 51 (return from exception, plain or authenticated) reports 0x1A, and every other bit reports 0x18.
- R9: Bit 52 traps only while `el1_wide`=1.
- R10: `hi_prio_exc`=1 suppresses the trap.
- R11: A trapping request gives one `trap_pulse` in the cycle after it is sampled, however long it is held. `trap_class` changes only in a pulse cycle and keeps its value until the next pulse.
- R12: A class index of 55 or above never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr_en | input | 1 | Write strobe for the control word |
| ctl_wr_data | input | 64 | Value to write |
| feat_avail | input | 5 | Optional-feature present flags |
| ctl_rd_data | output | 64 | Effective control word |
| req_valid | input | 1 | Instruction presented |
| req_class | input | 6 | Instruction-class index (bit position) |
| req_level | input | 2 | Current exception level |
| el1_wide | input | 1 | EL1 uses the 64-bit execution state |
| hyp_impl | input | 1 | Hypervisor level implemented |
| hyp_on_sec | input | 1 | Hypervisor enabled in current security state |
| host_e2h | input | 1 | Host-mode pair, first bit |
| host_tge | input | 1 | Host-mode pair, second bit |
| outer_present | input | 1 | Outermost level implemented |
| outer_trap_en | input | 1 | Outermost level's fine trap enable |
| hi_prio_exc | input | 1 | Instruction raises a higher-priority exception |
| trap_pulse | output | 1 | One-cycle trap request |
| trap_target | output | 2 | Target level (2 while pulsing) |
| trap_class | output | 6 | Exception class code of the last trap |

## Verification
The sequencer is the only state that exists apart from the control word. Suppose it were stuck in ST_HOLD or ST_FIRE. Then the next trapping request would show no pulse, or a pulse in two consecutive cycles, one cycle after sampling. A corrupt control word shows up at once on `ctl_rd_data`, and it shows up at the next request as a trap that is missing or out of place. A class latch loaded at the wrong moment makes `trap_class` move in a cycle without a pulse, and the bench's sample after a held request catches that.

// File: rtl/itf_pkg.sv
package itf_pkg;
    localparam int WORD_W    = 64;
    localparam int LIVE_BITS = 55;
    localparam int IDX_W     = $clog2(WORD_W);
    localparam int EC_W      = 6;
    localparam int LVL_W     = 2;
    localparam int FEAT_N    = 5;

    localparam logic [EC_W-1:0]  EC_SYSINSN = 6'h18;
    localparam logic [EC_W-1:0]  EC_SUPCALL = 6'h15;
    localparam logic [EC_W-1:0]  EC_EXCRET  = 6'h1A;
    localparam logic [LVL_W-1:0] LVL_HYP    = 2'd2;

    localparam int FT_RANGE   = 0;
    localparam int FT_OSH     = 1;
    localparam int FT_ATPRIV  = 2;
    localparam int FT_PREDR   = 3;
    localparam int FT_PERSIST = 4;

    typedef enum logic [1:0] {
        COV_EL1      = 2'd0,
        COV_BOTH     = 2'd1,
        COV_EL0_WIDE = 2'd2
    } cover_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } seq_state_e;

    function automatic cover_e cover_of(input int idx);
        case (idx)
            54, 50, 49, 48, 11, 10, 9, 8, 7: cover_of = COV_BOTH;
            52:                              cover_of = COV_EL0_WIDE;
            default:                         cover_of = COV_EL1;
        endcase
    endfunction

    function automatic logic [EC_W-1:0] code_of(input int idx);
        case (idx)
            53, 52:  code_of = EC_SUPCALL;
            51:      code_of = EC_EXCRET;
            default: code_of = EC_SYSINSN;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] keep_mask(input logic [FEAT_N-1:0] f);
        logic [WORD_W-1:0] m;
        m = '0;
        m[LIVE_BITS-1:0] = '1;
        if (!f[FT_RANGE]) begin
            m[41:34] = '0;
            m[27:24] = '0;
        end
        if (!f[FT_OSH])     m[27:18] = '0;
        if (!f[FT_ATPRIV])  m[17:16] = '0;
        if (!f[FT_PREDR])   m[50:48] = '0;
        if (!f[FT_PERSIST]) m[9]     = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/itf_ctl_reg.sv
module itf_ctl_reg
    import itf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [FEAT_N-1:0] feat,
    output logic [WORD_W-1:0] word_eff
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] keep;

    assign keep     = keep_mask(feat);
    assign word_eff = word_q & keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr_en)
            word_q <= wr_data & keep;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        word_eff[WORD_W-1:LIVE_BITS] == '0); // R2

    AST_ATPRIV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !feat[FT_ATPRIV] |-> word_eff[17:16] == 2'b00); // R3
endmodule

// File: rtl/itf_qualify.sv
module itf_qualify
    import itf_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_class,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              el1_wide,
    input  logic              hyp_impl,
    input  logic              hyp_on_sec,
    input  logic              host_e2h,
    input  logic              host_tge,
    input  logic              outer_present,
    input  logic              outer_trap_en,
    input  logic              hi_prio_exc,
    output logic              hit,
    output logic [EC_W-1:0]   code
);
    logic              at_el0, at_el1, host_mode, gate_ok, in_range;
    logic [WORD_W-1:0] elig;
    logic [EC_W-1:0]   code_tab [WORD_W];

    assign at_el0    = (req_level == 2'd0);
    assign at_el1    = (req_level == 2'd1);
    assign host_mode = host_e2h & host_tge;
    assign gate_ok   = hyp_impl & hyp_on_sec & (!outer_present | outer_trap_en);
    assign in_range  = (int'(req_class) < LIVE_BITS);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i >= LIVE_BITS) begin : g_rsvd
            assign elig[i] = 1'b0;
        end else begin : g_live
            localparam cover_e COV = cover_of(i);
            if (COV == COV_BOTH) begin : g_both
                assign elig[i] = (at_el0 | at_el1) & !host_mode;
            end else if (COV == COV_EL0_WIDE) begin : g_el0w
                assign elig[i] = at_el0 & el1_wide & !host_mode;
            end else begin : g_el1
                assign elig[i] = at_el1;
            end
        end
        assign code_tab[i] = code_of(i);
    end

    always_comb begin
        hit  = req_valid & in_range & gate_ok & !hi_prio_exc
             & word[req_class] & elig[req_class];
        code = code_tab[req_class];
    end
endmodule

// File: rtl/itf_seq.sv
module itf_seq
    import itf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             hit,
    input  logic [EC_W-1:0]  code,
    output logic             trap_pulse,
    output logic [LVL_W-1:0] trap_target,
    output logic [EC_W-1:0]  trap_class
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)        state_d = ST_FIRE;
            ST_FIRE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trap_class <= '0;
        else if (state_q == ST_IDLE && hit)
            trap_class <= code;
    end

    assign trap_pulse  = (state_q == ST_FIRE);
    assign trap_target = trap_pulse ? LVL_HYP : '0;

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse); // R11

    AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> $stable(trap_class)); // R11

    AST_TARGET_HYP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> trap_target == LVL_HYP); // R8
endmodule

// File: rtl/instr_trap_filter.sv
module instr_trap_filter
    import itf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_en,
    input  logic [63:0] ctl_wr_data,
    input  logic [4:0]  feat_avail,
    output logic [63:0] ctl_rd_data,
    input  logic        req_valid,
    input  logic [5:0]  req_class,
    input  logic [1:0]  req_level,
    input  logic        el1_wide,
    input  logic        hyp_impl,
    input  logic        hyp_on_sec,
    input  logic        host_e2h,
    input  logic        host_tge,
    input  logic        outer_present,
    input  logic        outer_trap_en,
    input  logic        hi_prio_exc,
    output logic        trap_pulse,
    output logic [1:0]  trap_target,
    output logic [5:0]  trap_class
);
    logic            hit;
    logic [EC_W-1:0] code;

    itf_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .feat     (feat_avail),
        .word_eff (ctl_rd_data)
    );

    itf_qualify u_qual (
        .word          (ctl_rd_data),
        .req_valid     (req_valid),
        .req_class     (req_class),
        .req_level     (req_level),
        .el1_wide      (el1_wide),
        .hyp_impl      (hyp_impl),
        .hyp_on_sec    (hyp_on_sec),
        .host_e2h      (host_e2h),
        .host_tge      (host_tge),
        .outer_present (outer_present),
        .outer_trap_en (outer_trap_en),
        .hi_prio_exc   (hi_prio_exc),
        .hit           (hit),
        .code          (code)
    );

    itf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .hit         (hit),
        .code        (code),
        .trap_pulse  (trap_pulse),
        .trap_target (trap_target),
        .trap_class  (trap_class)
    );

    AST_HIPRI_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_prio_exc |=> !trap_pulse); // R10

    AST_HOST_EL0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_level == 2'd0 && host_e2h && host_tge) |=> !trap_pulse); // R6

    AST_UPPER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        req_level[1] |=> !trap_pulse); // R7

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!hyp_impl || !hyp_on_sec || (outer_present && !outer_trap_en)) |=> !trap_pulse); // R5

    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_class) >= LIVE_BITS) |=> !trap_pulse); // R12
endmodule

// File: tb/instr_trap_filter_bench.sv
`timescale 1ns/1ps
module instr_trap_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [63:0] ctl_wr_data = '0;
    logic [4:0]  feat_avail = '1;
    logic [63:0] ctl_rd_data;
    logic        req_valid = 1'b0;
    logic [5:0]  req_class = '0;
    logic [1:0]  req_level = '0;
    logic        el1_wide = 1'b1;
    logic        hyp_impl = 1'b1;
    logic        hyp_on_sec = 1'b1;
    logic        host_e2h = 1'b0;
    logic        host_tge = 1'b0;
    logic        outer_present = 1'b1;
    logic        outer_trap_en = 1'b1;
    logic        hi_prio_exc = 1'b0;
    logic        trap_pulse;
    logic [1:0]  trap_target;
    logic [5:0]  trap_class;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [63:0] LIVE_ALL = 64'h007F_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    instr_trap_filter u_instr_trap_filter (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .feat_avail(feat_avail), .ctl_rd_data(ctl_rd_data), .req_valid(req_valid),
        .req_class(req_class), .req_level(req_level), .el1_wide(el1_wide),
        .hyp_impl(hyp_impl), .hyp_on_sec(hyp_on_sec), .host_e2h(host_e2h),
        .host_tge(host_tge), .outer_present(outer_present), .outer_trap_en(outer_trap_en),
        .hi_prio_exc(hi_prio_exc), .trap_pulse(trap_pulse), .trap_target(trap_target),
        .trap_class(trap_class)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [63:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic env_default();
        el1_wide = 1'b1; hyp_impl = 1'b1; hyp_on_sec = 1'b1;
        host_e2h = 1'b0; host_tge = 1'b0; outer_present = 1'b1;
        outer_trap_en = 1'b1; hi_prio_exc = 1'b0; feat_avail = '1;
    endtask

    task automatic req(input int cls, input int lvl, input bit exp_trap,
                       input logic [5:0] exp_code, input string tag);
        @(negedge clk);
        req_class = cls[5:0];
        req_level = lvl[1:0];
        req_valid = 1'b1;
        @(negedge clk);
        chk(tag, {63'd0, trap_pulse}, {63'd0, exp_trap});
        if (exp_trap) begin
            chk(tag, {58'd0, trap_class}, {58'd0, exp_code});
            chk(tag, {62'd0, trap_target}, 64'd2);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(tag, {63'd0, trap_pulse}, 64'd0);
    endtask

    task automatic t_reset_r1();
        chk("R1 word", ctl_rd_data, 64'd0);
        chk("R1 pulse", {63'd0, trap_pulse}, 64'd0);
        chk("R1 class", {58'd0, trap_class}, 64'd0);
        chk("R1 target", {62'd0, trap_target}, 64'd0);
    endtask

    task automatic t_reserved_r2();
        wr('1);
        chk("R2 reserved zero", ctl_rd_data, LIVE_ALL);
    endtask

    task automatic t_feature_r3();
        logic [63:0] exp;
        exp = LIVE_ALL;
        exp[50:48] = '0; exp[41:34] = '0; exp[27:16] = '0; exp[9] = 1'b0;
        feat_avail = '0;
        wr('1);
        chk("R3 gated bits zero", ctl_rd_data, exp);
        req(40, 1, 1'b0, 6'h00, "R3 gated bit no trap");
        req(9, 0, 1'b0, 6'h00, "R3 gated bit 9 no trap");
        req(33, 1, 1'b1, 6'h18, "R3 ungated bit traps");
        feat_avail = '1;
        wr('1);
        chk("R3 all features", ctl_rd_data, LIVE_ALL);
    endtask

    task automatic t_clear_r4();
        wr(64'h1 << 12);
        req(13, 1, 1'b0, 6'h00, "R4 clear bit");
        req(12, 1, 1'b1, 6'h18, "R4 set bit");
        wr('1);
    endtask

    task automatic t_gate_r5();
        hyp_impl = 1'b0;
        req(12, 1, 1'b0, 6'h00, "R5 no hypervisor");
        hyp_impl = 1'b1; hyp_on_sec = 1'b0;
        req(12, 1, 1'b0, 6'h00, "R5 hypervisor off in state");
        hyp_on_sec = 1'b1; outer_trap_en = 1'b0;
        req(12, 1, 1'b0, 6'h00, "R5 outer enable clear");
        outer_present = 1'b0;
        req(12, 1, 1'b1, 6'h18, "R5 outer absent");
        env_default();
    endtask

    task automatic t_host_r6();
        host_e2h = 1'b1; host_tge = 1'b1;
        req(7, 0, 1'b0, 6'h00, "R6 host EL0");
        req(7, 1, 1'b0, 6'h00, "R6 host EL1 both-level bit");
        req(52, 0, 1'b0, 6'h00, "R6 host EL0 supervisor call");
        req(12, 1, 1'b1, 6'h18, "R6 EL1-only unaffected");
        host_tge = 1'b0;
        req(7, 0, 1'b1, 6'h18, "R6 pair not both set");
        env_default();
    endtask

    task automatic t_levels_r7();
        req(12, 0, 1'b0, 6'h00, "R7 EL1-only at EL0");
        req(12, 2, 1'b0, 6'h00, "R7 level 2");
        req(54, 3, 1'b0, 6'h00, "R7 level 3");
        req(54, 0, 1'b1, 6'h18, "R7 both-level at EL0");
        req(52, 1, 1'b0, 6'h00, "R7 EL0 call bit at EL1");
    endtask

    task automatic t_codes_r8();
        req(53, 1, 1'b1, 6'h15, "R8 EL1 supervisor call");
        req(52, 0, 1'b1, 6'h15, "R8 EL0 supervisor call");
        req(51, 1, 1'b1, 6'h1A, "R8 exception return");
        req(30, 1, 1'b1, 6'h18, "R8 system instruction");
    endtask

    task automatic t_wide_r9();
        el1_wide = 1'b0;
        req(52, 0, 1'b0, 6'h00, "R9 EL1 narrow");
        req(54, 0, 1'b1, 6'h18, "R9 other bit unaffected");
        env_default();
    endtask

    task automatic t_hipri_r10();
        hi_prio_exc = 1'b1;
        req(51, 1, 1'b0, 6'h00, "R10 return suppressed");
        req(12, 1, 1'b0, 6'h00, "R10 system suppressed");
        env_default();
    endtask

    task automatic t_held_r11();
        int pulses;
        pulses = 0;
        @(negedge clk);
        req_class = 6'd51; req_level = 2'd1; req_valid = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (trap_pulse) pulses++;
        end
        chk("R11 one pulse while held", pulses, 64'd1);
        chk("R11 class held", {58'd0, trap_class}, 64'h1A);
        req_class = 6'd30;
        @(negedge clk);
        chk("R11 class stable without pulse", {58'd0, trap_class}, 64'h1A);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 idle after release", {63'd0, trap_pulse}, 64'd0);
        req(30, 1, 1'b1, 6'h18, "R11 new request pulses");
    endtask

    task automatic t_range_r12();
        req(55, 1, 1'b0, 6'h00, "R12 index 55");
        req(63, 0, 1'b0, 6'h00, "R12 index 63");
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_reserved_r2();
        t_feature_r3();
        t_clear_r4();
        t_gate_r5();
        t_host_r6();
        t_levels_r7();
        t_codes_r8();
        t_wide_r9();
        t_hipri_r10();
        t_held_r11();
        t_range_r12();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule